// File: doc/BRIEF.md
# LED Driver Fault Manager

This block sits between the comparator bank of a boost-type LED driver and its power stage. It takes raw, asynchronous digital flags from the analog comparators. It then decides which protective actions apply: inhibit the boost gate drive, inhibit the dimming-switch drive, pull the open-drain fault indicator, switch off the 5 V gate-drive regulator, end the present switching cycle, or ask the soft-start sequencer for a fresh ramp.

The block keeps four fault policies apart. Load-path faults latch until the enable input has stayed low long enough to count as a shutdown request. Overtemperature uses three comparator levels: one trips the fault, one permits restart after a deglitch delay, and one releases the fault indicator. Switch overcurrent only cuts the running cycle. An analog-dim level below cutoff quietly blanks the drive. A supply undervoltage blocks operation while it lasts. Every comparator flag passes through a two-stage synchronizer before any decision uses it. A priority-encoded cause code reports which policy is in control.

Top module: `led_fault_mgr`

## Requirements
- R1: Each comparator flag passes a two-flop synchronizer. A level change applied before clock edge k reaches the non-latched outputs (gate/dim inhibit, cycle abort, fault pull for supply) after edge k+1. A latched fault shows after edge k+2.
- R2: While enable is high and the supply flag is clear, any of rail-low, sense-open, sense-over or overvoltage latches a fault. The latch drives gate inhibit, dim inhibit and fault pull high, and sets cause to 4.
- R3: A latched fault clears only at a clock edge where enable is low and has already been low on OFF_CYCLES consecutive earlier edges. A shorter low period leaves it set.
- R4: The synchronized overcurrent flag drives cycle_abort_o directly. It never changes gate inhibit, dim inhibit, fault pull or cause.
- R5: While the upper thermal flag is set, the thermal monitor goes hot. Gate inhibit, dim inhibit, fault pull and vdr_off_o are all high, and cause is 3.
- R6: When both the upper and the restart thermal flags are clear, a deglitch wait of DG_CYCLES edges begins. A return of the restart flag sends the monitor back to hot. At the end of the wait, if enable is high, the monitor returns to normal, vdr_off_o drops, and ss_restart_o pulses for exactly one cycle. While enable is low, the monitor keeps waiting.
- R7: The thermal fault-pin request is set by the upper thermal flag and cleared only when the release flag is low, whatever the restart state.
- R8: The adim-low flag drives gate and dim inhibit high without fault pull and sets cause 1. The outputs recover when the flag clears.
- R9: The supply undervoltage flag drives gate inhibit, dim inhibit and fault pull high, sets cause 2, and prevents any latched fault from being set while present.
- R10: cause_o encodes 0 none, 1 adim, 2 supply, 3 thermal, 4 latched. The highest active value wins. Gate and dim inhibit are high exactly when cause is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable from the power sequencer (synchronous) |
| rail_lo_i | input | 1 | A current-sense pin is below the absolute rail threshold |
| sense_open_i | input | 1 | Sense difference below the negative open limit |
| sense_over_i | input | 1 | Sense difference above the overload limit |
| ovp_i | input | 1 | Overvoltage feedback above threshold |
| ocp_i | input | 1 | Switch current above the cycle limit |
| t_hot_i | input | 1 | Die temperature above the trip level |
| t_warm_i | input | 1 | Die temperature above the restart level |
| t_rel_i | input | 1 | Die temperature above the indicator-release level |
| adim_low_i | input | 1 | Analog dim voltage below cutoff |
| uvlo_i | input | 1 | One of the regulators is below its undervoltage level |
| gate_inh_o | output | 1 | Force boost gate drive low |
| dim_inh_o | output | 1 | Force dimming switch drive low |
| fault_pull_o | output | 1 | Pull the open-drain fault indicator low |
| vdr_off_o | output | 1 | Switch off the 5 V gate-drive regulator |
| cycle_abort_o | output | 1 | End the present switching cycle |
| ss_restart_o | output | 1 | One-cycle request for a new soft-start |
| cause_o | output | 3 | Priority-encoded active cause |

## Verification
The bench targets the latch-clear boundary. A low enable one cycle shorter than required must leave the fault set; a design that counts one too few would release early. It stretches the thermal deglitch window, raises the restart flag again in the middle of the wait, and holds enable low through the end of the wait. A design that restarts on the wrong condition would pulse the restart request early or while disabled. It also drops the release flag before restart and raises supply undervoltage together with overvoltage. Wrong arbitration would show as a stuck fault indicator, or as a latch that survives the undervoltage.

// File: rtl/led_fault_pkg.sv
package led_fault_pkg;

    typedef struct packed {
        logic rail_lo;
        logic sense_open;
        logic sense_over;
        logic ovp;
        logic ocp;
        logic t_hot;
        logic t_warm;
        logic t_rel;
        logic adim_low;
        logic uvlo;
    } fm_flags_t;

    localparam int FM_NFLAGS = $bits(fm_flags_t);

    typedef enum logic [1:0] {
        TH_OK   = 2'd0,
        TH_HOT  = 2'd1,
        TH_WAIT = 2'd2
    } th_state_e;

    typedef enum logic [2:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_ADIM   = 3'd1,
        CAUSE_SUPPLY = 3'd2,
        CAUSE_THERM  = 3'd3,
        CAUSE_LATCH  = 3'd4
    } cause_e;

    function automatic logic latch_trigger(input fm_flags_t f);
        return f.rail_lo | f.sense_open | f.sense_over | f.ovp;
    endfunction

endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/fm_latch.sv
module fm_latch
    import led_fault_pkg::*;
#(
    parameter int OFF_CYCLES = 2_000_000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en_i,
    input  fm_flags_t flags,
    output logic      latched_o
);
    localparam int OFF_W = $clog2(OFF_CYCLES + 1);
    localparam logic [OFF_W-1:0] OFF_LIMIT = OFF_W'(OFF_CYCLES);

    logic [OFF_W-1:0] off_cnt;
    logic             off_done;
    logic             set_req;

    assign off_done = (off_cnt == OFF_LIMIT);
    assign set_req  = en_i & ~flags.uvlo & latch_trigger(flags);

    always_ff @(posedge clk) begin
        if (rst) begin
            off_cnt <= '0;
        end else if (en_i) begin
            off_cnt <= '0;
        end else if (!off_done) begin
            off_cnt <= off_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latched_o <= 1'b0;
        end else if (set_req) begin
            latched_o <= 1'b1;
        end else if (off_done && !en_i) begin
            latched_o <= 1'b0;
        end
    end
endmodule

// File: rtl/fm_thermal.sv
module fm_thermal
    import led_fault_pkg::*;
#(
    parameter int DG_CYCLES = 200_000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en_i,
    input  fm_flags_t flags,
    output logic      active_o,
    output logic      pin_o,
    output logic      restart_o
);
    localparam int DG_W = $clog2(DG_CYCLES + 1);
    localparam logic [DG_W-1:0] DG_LIMIT = DG_W'(DG_CYCLES);

    th_state_e        state;
    logic [DG_W-1:0]  dg_cnt;
    logic             still_warm;

    assign still_warm = flags.t_warm | flags.t_hot;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= TH_OK;
            dg_cnt    <= '0;
            restart_o <= 1'b0;
        end else begin
            restart_o <= 1'b0;
            unique case (state)
                TH_OK: begin
                    if (flags.t_hot) state <= TH_HOT;
                end
                TH_HOT: begin
                    if (!still_warm) begin
                        state  <= TH_WAIT;
                        dg_cnt <= '0;
                    end
                end
                TH_WAIT: begin
                    if (still_warm) begin
                        state <= TH_HOT;
                    end else if (dg_cnt == DG_LIMIT) begin
                        if (en_i) begin
                            state     <= TH_OK;
                            restart_o <= 1'b1;
                        end
                    end else begin
                        dg_cnt <= dg_cnt + 1'b1;
                    end
                end
                default: state <= TH_OK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)               pin_o <= 1'b0;
        else if (flags.t_hot)  pin_o <= 1'b1;
        else if (!flags.t_rel) pin_o <= 1'b0;
    end

    assign active_o = (state != TH_OK);
endmodule

// File: rtl/fm_arbiter.sv
module fm_arbiter
    import led_fault_pkg::*;
(
    input  fm_flags_t flags,
    input  logic      latched,
    input  logic      th_active,
    input  logic      th_pin,
    output logic      gate_inh,
    output logic      dim_inh,
    output logic      fault_pull,
    output logic      vdr_off,
    output logic      cycle_abort,
    output cause_e    cause
);
    always_comb begin
        if (latched)             cause = CAUSE_LATCH;
        else if (th_active)      cause = CAUSE_THERM;
        else if (flags.uvlo)     cause = CAUSE_SUPPLY;
        else if (flags.adim_low) cause = CAUSE_ADIM;
        else                     cause = CAUSE_NONE;
    end

    assign gate_inh    = latched | th_active | flags.uvlo | flags.adim_low;
    assign dim_inh     = gate_inh;
    assign fault_pull  = latched | th_pin | flags.uvlo;
    assign vdr_off     = th_active;
    assign cycle_abort = flags.ocp;
endmodule

// File: rtl/led_fault_mgr.sv
module led_fault_mgr
    import led_fault_pkg::*;
#(
    parameter int OFF_CYCLES  = 2_000_000,
    parameter int DG_CYCLES   = 200_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic       rail_lo_i,
    input  logic       sense_open_i,
    input  logic       sense_over_i,
    input  logic       ovp_i,
    input  logic       ocp_i,
    input  logic       t_hot_i,
    input  logic       t_warm_i,
    input  logic       t_rel_i,
    input  logic       adim_low_i,
    input  logic       uvlo_i,
    output logic       gate_inh_o,
    output logic       dim_inh_o,
    output logic       fault_pull_o,
    output logic       vdr_off_o,
    output logic       cycle_abort_o,
    output logic       ss_restart_o,
    output logic [2:0] cause_o
);
    fm_flags_t raw_flags;
    fm_flags_t sync_flags;
    logic [FM_NFLAGS-1:0] sync_bits;
    logic   latched;
    logic   th_active;
    logic   th_pin;
    cause_e cause;

    always_comb begin
        raw_flags.rail_lo    = rail_lo_i;
        raw_flags.sense_open = sense_open_i;
        raw_flags.sense_over = sense_over_i;
        raw_flags.ovp        = ovp_i;
        raw_flags.ocp        = ocp_i;
        raw_flags.t_hot      = t_hot_i;
        raw_flags.t_warm     = t_warm_i;
        raw_flags.t_rel      = t_rel_i;
        raw_flags.adim_low   = adim_low_i;
        raw_flags.uvlo       = uvlo_i;
    end

    fm_sync #(.W(FM_NFLAGS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_flags),
        .q   (sync_bits)
    );
    assign sync_flags = fm_flags_t'(sync_bits);

    fm_latch #(.OFF_CYCLES(OFF_CYCLES)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en_i),
        .flags     (sync_flags),
        .latched_o (latched)
    );

    fm_thermal #(.DG_CYCLES(DG_CYCLES)) u_thermal (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en_i),
        .flags     (sync_flags),
        .active_o  (th_active),
        .pin_o     (th_pin),
        .restart_o (ss_restart_o)
    );

    fm_arbiter u_arb (
        .flags       (sync_flags),
        .latched     (latched),
        .th_active   (th_active),
        .th_pin      (th_pin),
        .gate_inh    (gate_inh_o),
        .dim_inh     (dim_inh_o),
        .fault_pull  (fault_pull_o),
        .vdr_off     (vdr_off_o),
        .cycle_abort (cycle_abort_o),
        .cause       (cause)
    );

    assign cause_o = cause;
endmodule

// File: rtl/led_fault_mgr_chk.sv
module led_fault_mgr_chk (
    input logic       clk,
    input logic       rst,
    input logic       en_i,
    input logic       gate_inh_o,
    input logic       dim_inh_o,
    input logic       fault_pull_o,
    input logic       vdr_off_o,
    input logic       ss_restart_o,
    input logic [2:0] cause_o
);
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cause_o == 3'd4 && en_i) |=> (cause_o == 3'd4)); // R3

    AST_LATCH_PIN: assert property (@(posedge clk) disable iff (rst)
        (cause_o == 3'd4) |-> (fault_pull_o && gate_inh_o && dim_inh_o)); // R2

    AST_VDR_BLANKS: assert property (@(posedge clk) disable iff (rst)
        vdr_off_o |-> (gate_inh_o && dim_inh_o)); // R5

    AST_RESTART_EN: assert property (@(posedge clk) disable iff (rst)
        ss_restart_o |-> ($past(en_i) && $past(vdr_off_o) && !vdr_off_o)); // R6

    AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (rst)
        ss_restart_o |=> !ss_restart_o); // R6

    AST_ADIM_SILENT: assert property (@(posedge clk) disable iff (rst)
        (cause_o == 3'd1) |-> (!fault_pull_o && gate_inh_o && !vdr_off_o)); // R8

    AST_SUPPLY_PIN: assert property (@(posedge clk) disable iff (rst)
        (cause_o == 3'd2) |-> (fault_pull_o && gate_inh_o)); // R9

    AST_CAUSE_RANGE: assert property (@(posedge clk) disable iff (rst)
        (cause_o <= 3'd4) && ((cause_o != 3'd0) == gate_inh_o)); // R10
endmodule

bind led_fault_mgr led_fault_mgr_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .en_i         (en_i),
    .gate_inh_o   (gate_inh_o),
    .dim_inh_o    (dim_inh_o),
    .fault_pull_o (fault_pull_o),
    .vdr_off_o    (vdr_off_o),
    .ss_restart_o (ss_restart_o),
    .cause_o      (cause_o)
);

// File: tb/led_fault_mgr_bench.sv
`timescale 1ns/1ps
module led_fault_mgr_bench;
    localparam int OFF = 20;
    localparam int DG  = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic rail_lo = 0, s_open = 0, s_over = 0, ovp = 0, ocp = 0;
    logic t_hot = 0, t_warm = 0, t_rel = 0, adim = 0, uvlo = 0;
    logic gate_inh, dim_inh, fault_pull, vdr_off, cyc_abort, restart;
    logic [2:0] cause;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    led_fault_mgr #(.OFF_CYCLES(OFF), .DG_CYCLES(DG)) u_led_fault_mgr (
        .clk(clk), .rst(rst), .en_i(en),
        .rail_lo_i(rail_lo), .sense_open_i(s_open), .sense_over_i(s_over),
        .ovp_i(ovp), .ocp_i(ocp), .t_hot_i(t_hot), .t_warm_i(t_warm),
        .t_rel_i(t_rel), .adim_low_i(adim), .uvlo_i(uvlo),
        .gate_inh_o(gate_inh), .dim_inh_o(dim_inh), .fault_pull_o(fault_pull),
        .vdr_off_o(vdr_off), .cycle_abort_o(cyc_abort), .ss_restart_o(restart),
        .cause_o(cause)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d at cycle %0d", tag, what, got, exp, cyc);
        end
    endtask

    // behavioural reference model: bit 9 rail, 8 open, 7 over, 6 ovp, 5 ocp,
    // 4 hot, 3 warm, 2 rel, 1 adim, 0 uvlo
    logic [9:0] hist[$];
    int m_latch, m_off, m_th, m_dg, m_pin, m_rst_pulse;

    function automatic logic [9:0] m_s2();
        return (hist.size() >= 2) ? hist[1] : 10'd0;
    endfunction

    always @(posedge clk) begin
        logic [9:0] o;
        cyc++;
        if (rst) begin
            hist.delete();
            m_latch = 0; m_off = 0; m_th = 0; m_dg = 0; m_pin = 0; m_rst_pulse = 0;
        end else begin
            o = m_s2();
            if (en && !o[0] && (o[9] || o[8] || o[7] || o[6])) m_latch = 1;
            else if (!en && m_off >= OFF) m_latch = 0;
            if (en) m_off = 0; else if (m_off < OFF) m_off++;
            m_rst_pulse = 0;
            if (o[4]) m_pin = 1; else if (!o[2]) m_pin = 0;
            if (m_th == 0) begin
                if (o[4]) m_th = 1;
            end else if (m_th == 1) begin
                if (!o[3] && !o[4]) begin m_th = 2; m_dg = 0; end
            end else begin
                if (o[3] || o[4]) m_th = 1;
                else if (m_dg == DG) begin
                    if (en) begin m_th = 0; m_rst_pulse = 1; end
                end else m_dg++;
            end
            hist.push_front({rail_lo, s_open, s_over, ovp, ocp, t_hot, t_warm, t_rel, adim, uvlo});
            if (hist.size() > 2) void'(hist.pop_back());
        end
        if (cyc > 5000 && !done) begin
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    always @(negedge clk) begin
        logic [9:0] s;
        int e_gate, e_pull, e_cause;
        if (!rst && !done) begin
            s = m_s2();
            e_gate = (m_latch != 0 || m_th != 0 || s[0] || s[1]) ? 1 : 0;
            e_pull = (m_latch != 0 || m_pin != 0 || s[0]) ? 1 : 0;
            e_cause = m_latch ? 4 : (m_th != 0) ? 3 : s[0] ? 2 : s[1] ? 1 : 0;
            chk("R8", "gate_inh", int'(gate_inh), e_gate);
            chk("R2", "dim_inh", int'(dim_inh), e_gate);
            chk("R7", "fault_pull", int'(fault_pull), e_pull);
            chk("R5", "vdr_off", int'(vdr_off), (m_th != 0) ? 1 : 0);
            chk("R4", "cycle_abort", int'(cyc_abort), int'(s[5]));
            chk("R6", "ss_restart", int'(restart), m_rst_pulse);
            chk("R10", "cause", int'(cause), e_cause);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic look(input string tag, input string what, input int got, input int exp);
        @(negedge clk);
        chk(tag, what, got, exp);
    endtask

    task automatic clear_latch();
        en = 0; step(OFF + 3); en = 1; step(2);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        step(3);
        rst = 0;
        @(negedge clk);
        chk("R10", "reset cause", int'(cause), 0);
        chk("R7", "reset fault_pull", int'(fault_pull), 0);
        chk("R5", "reset vdr_off", int'(vdr_off), 0);
        step(1);
        en = 1; step(2);

        // R1: two-stage delay on adim cutoff
        adim = 1; step(1);
        @(negedge clk); chk("R1", "gate after 1 edge", int'(gate_inh), 0);
        step(1);
        @(negedge clk); chk("R1", "gate after 2 edges", int'(gate_inh), 1);
        chk("R8", "adim no fault pull", int'(fault_pull), 0);
        chk("R8", "adim cause", int'(cause), 1);
        adim = 0; step(3);
        look("R8", "adim resume", int'(gate_inh), 0);

        // R4: overcurrent
        ocp = 1; step(3);
        look("R4", "abort on", int'(cyc_abort), 1);
        chk("R4", "ocp no fault", int'(fault_pull), 0);
        chk("R4", "ocp no gate inhibit", int'(gate_inh), 0);
        ocp = 0; step(3);
        look("R4", "abort off", int'(cyc_abort), 0);

        // R2: each latch source
        for (int k = 0; k < 4; k++) begin
            rail_lo = (k == 0); s_open = (k == 1); s_over = (k == 2); ovp = (k == 3);
            step(1);
            rail_lo = 0; s_open = 0; s_over = 0; ovp = 0;
            step(5);
            look("R2", "latched cause", int'(cause), 4);
            chk("R2", "latched pull", int'(fault_pull), 1);
            clear_latch();
            look("R3", "cleared after long low", int'(cause), 0);
        end

        // R3: short enable low keeps the latch
        ovp = 1; step(1); ovp = 0; step(4);
        en = 0; step(OFF); en = 1; step(2);
        look("R3", "short low keeps latch", int'(cause), 4);
        clear_latch();
        look("R3", "long low clears", int'(fault_pull), 0);

        // R9: supply undervoltage blocks latching
        uvlo = 1; ovp = 1; step(5);
        look("R9", "supply cause", int'(cause), 2);
        chk("R9", "supply pull", int'(fault_pull), 1);
        ovp = 0; uvlo = 0; step(4);
        look("R9", "no latch under uvlo", int'(cause), 0);

        // R5/R6/R7: thermal
        t_hot = 1; t_warm = 1; t_rel = 1; step(4);
        look("R5", "hot vdr_off", int'(vdr_off), 1);
        chk("R5", "hot cause", int'(cause), 3);
        t_hot = 0; step(4);
        look("R5", "still warm", int'(vdr_off), 1);
        t_warm = 0; step(DG / 2);
        t_warm = 1; step(3);
        t_warm = 0; step(DG - 2);
        look("R6", "still in deglitch", int'(vdr_off), 1);
        step(8);
        look("R6", "restarted", int'(vdr_off), 0);
        chk("R7", "pin held above release", int'(fault_pull), 1);
        t_rel = 0; step(3);
        look("R7", "pin released", int'(fault_pull), 0);

        // R7 release before restart, R6 disabled wait
        t_hot = 1; t_warm = 1; t_rel = 1; step(4);
        t_hot = 0; t_warm = 0; t_rel = 0; step(4);
        look("R7", "released while waiting", int'(fault_pull), 0);
        chk("R6", "waiting vdr", int'(vdr_off), 1);
        en = 0; step(DG + 6);
        look("R6", "no restart while disabled", int'(vdr_off), 1);
        en = 1; step(3);
        look("R6", "restart after enable", int'(vdr_off), 0);

        // R10: priority stack
        adim = 1; t_hot = 1; t_warm = 1; t_rel = 1; ovp = 1; step(1);
        ovp = 0; step(5);
        look("R10", "latch on top", int'(cause), 4);
        clear_latch();
        look("R10", "thermal next", int'(cause), 3);
        t_hot = 0; t_warm = 0; t_rel = 0; step(DG + 6);
        look("R10", "adim last", int'(cause), 1);
        adim = 0; step(3);
        look("R10", "all clear", int'(cause), 0);

        step(4);
        finish_run();
    end
endmodule